// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block turns a write request given as a byte address, a byte count and a stream of bytes into a series of aligned 32-bit program requests for a flash program engine. Each word gets its bytes in little-endian lane order. Any lane that the request does not cover is filled with 0xFF, which is the erased value, so the flash leaves that lane unchanged. Because of this padding the block never needs to read a word back before writing it.

A request starts with a one-cycle `start` pulse while the block is idle. Bytes then arrive on a valid/ready stream. The block places each byte in its lane. When a word is full, or when the last byte of the request has arrived, it presents the word on the program port and holds it until the engine accepts it. It then waits for the pass/fail answer on that word.

A passing word adds its real data bytes to the committed-byte total. A failing word ends the request at once with the error flag set, and no further word is issued.

Top module: `byte_word_packer`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err`, `in_ready` and `pgm_valid` are low, and `bytes_written` is zero.
- R2: Every `pgm_addr` presented with `pgm_valid` high has its two low bits equal to zero.
- R3: For an unaligned start address, the first word goes to the start address rounded down to a multiple of 4. Lanes below the start offset hold 0xFF and the request bytes follow from the start offset upward.
- R4: Once the head word is done, full words are issued at addresses that rise by 4 for each word.
- R5: When fewer than 4 bytes remain, the final word carries them in its lowest lanes, and its upper lanes hold 0xFF.
- R6: A request that starts and ends inside one word produces exactly one program request, padded on both sides.
- R7: A zero byte count raises `done` on the clock edge after `start`, with `err` low, `bytes_written` zero and no program request.
- R8: When a word reports failure, `done` and `err` rise on the next edge and no further program request is made.
- R9: `bytes_written` rises only when a word passes, and it rises by the number of real data bytes in that word.
- R10: Byte lane 0 is the lowest byte address and sits in `pgm_data[7:0]`; lane 3 sits in `pgm_data[31:24]`.
- R11: While `pgm_valid` waits for `pgm_ready`, the address and data stay stable. `in_ready` and `pgm_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a request; only sampled while idle |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| byte_count | input | LEN_W | Number of data bytes in the request |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | The packer takes the offered byte |
| pgm_valid | output | 1 | A word program request is pending |
| pgm_addr | output | ADDR_W | Word-aligned program address |
| pgm_data | output | 32 | Word to program, with uncovered lanes set to 0xFF |
| pgm_ready | input | 1 | The engine accepts the pending request |
| pgm_done | input | 1 | The engine reports the result of the accepted word |
| pgm_fail | input | 1 | Qualifies `pgm_done`: the word failed |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request ends |
| err | output | 1 | The last request ended on a failed word; held until the next start |
| bytes_written | output | LEN_W | Data bytes committed by the last request |

## Verification
The request table mixes aligned and unaligned starts with short and long counts.

- An aligned start with whole words separates the full-word path from the padding paths.
- A start at each non-zero offset exercises head padding, and counts that leave one, two or three trailing bytes exercise tail padding.
- A two-byte request in the middle of a word shows whether head and tail padding merge into a single write.
- Failures injected on the first word and on a middle word show that the request stops at once, and that the committed total counts only the words before the failure.
- Gaps in the byte stream and late acceptance on the program port exercise the holding behaviour on both sides.

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_count,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [31:0]       pgm_data,
  input  logic              pgm_ready,
  input  logic              pgm_done,
  input  logic              pgm_fail,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  bytes_written
);
  localparam int WORD_BYTES = 4;
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam logic [31:0] ERASED = '1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_ISSUE, S_WAIT} state_t;
  state_t state;

  logic [ADDR_W-1:0] word_addr;
  logic [31:0]       word;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  remaining;
  logic [LANE_W:0]   nbytes;

  wire last_lane = lane == LANE_W'(WORD_BYTES - 1);

  assign in_ready  = state == S_FILL;
  assign pgm_valid = state == S_ISSUE;
  assign pgm_addr  = word_addr;
  assign pgm_data  = word;
  assign busy      = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      word_addr     <= '0;
      word          <= ERASED;
      lane          <= '0;
      remaining     <= '0;
      nbytes        <= '0;
      done          <= 1'b0;
      err           <= 1'b0;
      bytes_written <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err           <= 1'b0;
          bytes_written <= '0;
          if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            word_addr <= {start_addr[ADDR_W-1:LANE_W], LANE_W'(0)};
            lane      <= start_addr[LANE_W-1:0];
            remaining <= byte_count;
            word      <= ERASED;
            nbytes    <= '0;
            state     <= S_FILL;
          end
        end
        S_FILL: if (in_valid) begin
          word[lane*8 +: 8] <= in_data;
          lane      <= lane + 1'b1;
          remaining <= remaining - 1'b1;
          nbytes    <= nbytes + 1'b1;
          if (last_lane || remaining == LEN_W'(1)) state <= S_ISSUE;
        end
        S_ISSUE: if (pgm_ready) state <= S_WAIT;
        S_WAIT: if (pgm_done) begin
          if (pgm_fail) begin
            err   <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            bytes_written <= bytes_written + LEN_W'(nbytes);
            if (remaining == '0) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              word_addr <= word_addr + ADDR_W'(WORD_BYTES);
              lane      <= '0;
              word      <= ERASED;
              nbytes    <= '0;
              state     <= S_FILL;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> pgm_addr[LANE_W-1:0] == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid && !pgm_ready |=> pgm_valid && $stable(pgm_addr) && $stable(pgm_data));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_valid && in_ready));

  p_fail_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT && pgm_done && pgm_fail |=> done && err && !busy);

  p_count_only_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_WAIT && pgm_done && !pgm_fail) && !(state == S_IDLE && start)
      |=> $stable(bytes_written));

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && start && byte_count == '0 |=> done && !err && !busy);
endmodule

// File: tb/test_byte_word_packer.sv
module test_byte_word_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h101, 32'h203, 32'h302, 32'h400,
                                          32'h512, 32'h621, 32'h700, 32'h7FC};
  localparam int V_CNT  [NV] = '{8, 2, 6, 11, 0, 3, 10, 4, 12};
  localparam int V_FAIL [NV] = '{-1, -1, -1, -1, -1, -1, 1, 0, -1};
  localparam int V_BASE [NV] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h50, 8'h60, 8'h70, 8'h80};

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic in_valid = 0;
  logic [7:0] in_data = '0;
  logic in_ready, pgm_valid, busy, done, err;
  logic [31:0] pgm_addr, pgm_data;
  logic pgm_ready = 0, pgm_done = 0, pgm_fail = 0;
  logic [15:0] bytes_written;

  int errors = 0, checks = 0, nw = 0;
  bit op_over = 0, finished = 0;
  logic [31:0] got_addr [8];
  logic [31:0] got_data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_word_packer i_byte_word_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .byte_count(byte_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pgm_valid(pgm_valid), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_ready(pgm_ready), .pgm_done(pgm_done), .pgm_fail(pgm_fail),
    .busy(busy), .done(done), .err(err), .bytes_written(bytes_written));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] addr, input int cnt, input int fail_at, input int base);
    logic [31:0] e_addr [8];
    logic [31:0] e_data [8];
    int e_n [8];
    int ne = 0, off, rem, k = 0, exp_bw = 0, exp_w;
    bit exp_err;
    off = int'(addr[1:0]);
    rem = cnt;
    while (rem > 0) begin
      e_addr[ne] = {addr[31:2], 2'b00} + 32'(4 * ne);
      e_data[ne] = '1;
      e_n[ne] = 0;
      for (int ln = (ne == 0) ? off : 0; ln < 4 && rem > 0; ln++) begin
        e_data[ne][ln*8 +: 8] = 8'(base + k);
        k++; rem--; e_n[ne]++;
      end
      ne++;
    end
    exp_err = fail_at >= 0 && fail_at < ne;
    exp_w = exp_err ? fail_at + 1 : ne;
    for (int w = 0; w < exp_w; w++) if (!(exp_err && w == fail_at)) exp_bw += e_n[w];

    @(negedge clk);
    start = 1; start_addr = addr; byte_count = 16'(cnt);
    nw = 0; op_over = 0;
    @(negedge clk);
    start = 0;
    fork
      begin : feeder
        int i = 0, t = 0;
        bit rdy;
        while (i < cnt && !op_over) begin
          if (t % 4 == 3) in_valid = 0;
          else begin in_valid = 1; in_data = 8'(base + i); end
          rdy = in_ready && in_valid;
          t++;
          @(posedge clk);
          if (rdy) i++;
          @(negedge clk);
        end
        in_valid = 0;
      end
      begin : engine
        while (!op_over) begin
          if (pgm_valid && nw < 8) begin
            got_addr[nw] = pgm_addr; got_data[nw] = pgm_data;
            if (nw % 2 == 1) @(negedge clk);
            pgm_ready = 1;
            @(negedge clk);
            pgm_ready = 0; pgm_done = 1; pgm_fail = (nw == fail_at);
            nw++;
            @(negedge clk);
            pgm_done = 0; pgm_fail = 0;
          end else @(negedge clk);
        end
      end
      begin : waiter
        while (!done) @(negedge clk);
        op_over = 1;
      end
    join
    chk(nw == exp_w, exp_err ? "R8 write count" : "R6 write count", 32'(nw), 32'(exp_w));
    for (int w = 0; w < exp_w && w < nw; w++) begin
      chk(got_addr[w] == e_addr[w], w == 0 ? "R3 head address" : "R4 word address", got_addr[w], e_addr[w]);
      chk(got_data[w] == e_data[w], w == 0 ? "R3/R10 head data" : "R5 word data", got_data[w], e_data[w]);
    end
    chk(err == exp_err, "R8 err flag", 32'(err), 32'(exp_err));
    chk(bytes_written == 16'(exp_bw), "R9 committed bytes", 32'(bytes_written), 32'(exp_bw));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1 idle flags", {busy, done, err}, 0);
    chk(!in_ready && !pgm_valid, "R1 handshakes low", {in_ready, pgm_valid}, 0);
    chk(bytes_written == 0, "R1 byte total", 32'(bytes_written), 0);

    for (int v = 0; v < NV; v++) run_op(V_ADDR[v], V_CNT[v], V_FAIL[v], V_BASE[v]);

    run_op(32'h101, 2, -1, 8'h20);
    chk(got_data[0] == 32'hFF2120FF, "R6 R10 single padded word", got_data[0], 32'hFF2120FF);
    run_op(32'h800, 4, -1, 8'h11);
    chk(got_data[0] == 32'h14131211, "R10 lane order", got_data[0], 32'h14131211);
    run_op(32'h902, 2, -1, 8'hA0);
    chk(got_data[0] == 32'hA1A0FFFF, "R3 head pad lanes", got_data[0], 32'hA1A0FFFF);
    run_op(32'hA00, 5, -1, 8'hB0);
    chk(got_data[1] == 32'hFFFFFFB4, "R5 tail pad lanes", got_data[1], 32'hFFFFFFB4);

    @(negedge clk);
    in_valid = 1; in_data = 8'h55;
    @(negedge clk);
    chk(!in_ready && !busy, "R11 stream ignored while idle", {in_ready, busy}, 0);
    in_valid = 0;
    start = 1; start_addr = 32'h40; byte_count = 0;
    @(negedge clk);
    start = 0;
    chk(done && !err && !busy, "R7 zero count done next edge", {done, err, busy}, 3'b100);
    chk(bytes_written == 0 && !pgm_valid, "R7 no write", {bytes_written, pgm_valid}, 0);
    @(negedge clk);
    chk(!done, "R7 done is a single pulse", 32'(done), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule